// File: doc/BRIEF.md
# Oversampling Serial Receiver with Character Queue

This block receives asynchronous serial characters from a single data line. A baud-tick enable, produced outside the block, marks each oversampling instant. There are 16 such ticks per bit in normal mode and 8 per bit in double-speed mode. The incoming line first passes through a synchronizer. A falling edge then aligns the sample counter to the start bit. Each bit is decided by a two-of-three vote over the samples at the bit's centre, so a single noisy sample cannot flip the bit.

Each completed character goes into a small queue together with its own parity-error and framing-error flags. The consumer sees the oldest character and its two flags on the outputs. It pops that character with a one-cycle read strobe. Dropping the receive enable stops reception at once, discards any partial frame and empties the queue. A character that arrives while the queue is full is dropped, and this sets a sticky overrun flag.

Top module: `uart_rx_top`

## Requirements
- R1: After reset the outputs `rx_avail`, `rx_perr`, `rx_ferr`, `rx_ovr` and `rx_data` are all zero.
- R2: With `dbl_speed`=0 a bit lasts 16 baud ticks. A frame is one low start bit, 8 data bits sent least significant bit first, a parity bit only when `par_en`=1, and one stop bit. Every byte value is received unchanged.
- R3: With `dbl_speed`=1 a bit lasts 8 baud ticks, and the frame format and results are the same as in R2.
- R4: Each bit is the majority of three consecutive ticks at the bit centre: ticks 7, 8 and 9 at 16x, or ticks 3, 4 and 5 at 8x, counted from 0 at the tick that first sees the line low. A disturbance lasting one tick inside a data bit does not change the received byte.
- R5: If the start-bit vote is high, the receiver returns to idle, stores nothing and keeps accepting later frames.
- R6: When `par_en`=1, the parity bit follows the data. With `par_odd`=0 the nine bits must XOR to 0, and with `par_odd`=1 they must XOR to 1. A mismatch sets `rx_perr` for that character. A character received with `par_en`=0 has `rx_perr`=0.
- R7: A stop bit that votes low sets `rx_ferr` for that character, and the character is still stored.
- R8: `rx_perr` and `rx_ferr` describe the character currently on `rx_data` and stay valid until it is read. The next character brings its own flags.
- R9: The queue holds 2 characters. `rx_avail` is high exactly when the queue is non-empty. Each cycle with `rd_en`=1 removes one character. A read of an empty queue has no effect.
- R10: A character that completes while the queue is full is discarded and sets `rx_ovr`. The flag stays set until the receiver is disabled or reset.
- R11: One cycle with `rx_en`=0 empties the queue and clears `rx_ovr`, both visible after the next clock edge. Any partial frame is discarded, and the line must return high before a new start bit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle oversampling enable |
| rxd | input | 1 | Asynchronous serial data line, idle high |
| rx_en | input | 1 | Receiver enable; low aborts and flushes |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| par_en | input | 1 | Expect and check a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_en | input | 1 | Pop the head character |
| rx_data | output | 8 | Head character, zero when empty |
| rx_avail | output | 1 | Queue non-empty |
| rx_perr | output | 1 | Parity error of the head character |
| rx_ferr | output | 1 | Framing error of the head character |
| rx_ovr | output | 1 | Sticky overrun indication |

## Verification
The bench sends every byte value in both speed modes. In normal mode it mixes odd and even parity and spoils the parity bit on every third frame, so a receiver with reversed bit order, a wrong bit length or a parity sense flipped for one polarity returns wrong bytes or wrong flags. One-tick glitches inside data bits and a start pulse too short to pass the vote are injected. A receiver that used a single sample would corrupt the byte, and one without start validation would store a spurious character. Two characters with different error flags are queued, to expose flags that are not stored per entry. The bench then overfills the queue, reads an empty queue, and disables the receiver in the middle of a frame. These cases catch a queue that overwrites its head, a counter that underflows, an overrun flag that clears too early, and a flush that leaves stale data or resumes a half-received frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int RX_DW = 8;

  typedef struct packed {
    logic [RX_DW-1:0] data;
    logic             perr;
    logic             ferr;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     tick,
  input  logic     line,
  input  logic     dbl,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     push,
  output rx_char_t push_char
);
  localparam int CW = $clog2(OS) + 1;
  localparam int BW = (RX_DW > 1) ? $clog2(RX_DW) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} st_t;

  st_t              st;
  logic [CW-1:0]    smp;
  logic [CW-1:0]    blen;
  logic [CW-1:0]    mid;
  logic [BW-1:0]    bcnt;
  logic [RX_DW-1:0] shreg;
  logic             v0, v1, vote, pbit;
  logic             dbl_l, par_l, odd_l, armed;

  // bit length follows the mode captured at the start edge
  assign blen = dbl_l ? CW'(OS / 2) : CW'(OS);
  assign mid  = blen >> 1;
  assign vote = (v0 & v1) | (v0 & line) | (v1 & line);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st    <= ST_IDLE;
      smp   <= '0;
      bcnt  <= '0;
      armed <= 1'b0;
      push  <= 1'b0;
    end else begin
      push <= 1'b0;
      if (st == ST_IDLE && line) armed <= 1'b1;
      if (tick) begin
        if (st == ST_IDLE) begin
          if (armed && !line) begin
            st    <= ST_START;
            smp   <= CW'(1);
            dbl_l <= dbl;
            par_l <= par_en;
            odd_l <= par_odd;
            armed <= 1'b0;
          end
        end else begin
          if (smp == blen - CW'(1)) smp <= '0;
          else                      smp <= smp + CW'(1);
          if (smp == mid - CW'(1)) v0 <= line;
          if (smp == mid)          v1 <= line;
          if (smp == blen - CW'(1)) begin
            case (st)
              ST_START: begin
                st   <= ST_DATA;
                bcnt <= '0;
              end
              ST_DATA: begin
                if (bcnt == BW'(RX_DW - 1)) st <= par_l ? ST_PAR : ST_STOP;
                else                        bcnt <= bcnt + BW'(1);
              end
              ST_PAR:  st <= ST_STOP;
              default: ;
            endcase
          end
          if (smp == mid + CW'(1)) begin
            case (st)
              ST_START: if (vote) st <= ST_IDLE;
              ST_DATA:  shreg <= {vote, shreg[RX_DW-1:1]};
              ST_PAR:   pbit <= vote;
              ST_STOP: begin
                push      <= 1'b1;
                push_char <= '{data: shreg,
                               perr: par_l & (^shreg ^ pbit ^ odd_l),
                               ferr: ~vote};
                st        <= ST_IDLE;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st == ST_IDLE) && !push);

  // R9
  push_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             push,
  input  rx_char_t         din,
  input  logic             rd,
  output logic [RX_DW-1:0] dout,
  output logic             dout_perr,
  output logic             dout_ferr,
  output logic             avail,
  output logic             ovr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rx_char_t      mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          full, pop, wr_ok;
  rx_char_t      head;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign avail = (cnt != '0);
  assign pop   = rd && avail;
  assign wr_ok = push && (!full || pop);

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovr    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop)   rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({wr_ok, pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: ;
      endcase
      if (push && !wr_ok) ovr <= 1'b1;
    end
  end

  assign head      = mem[rd_ptr];
  assign dout      = avail ? head.data : '0;
  assign dout_perr = avail & head.perr;
  assign dout_ferr = avail & head.ferr;

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));

  // R9
  pop_one_chk: assert property (@(posedge clk) disable iff (rst)
    en && pop && !push |=> cnt == $past(cnt) - (AW+1)'(1));

  // R10
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    en && push && full && !rd |=> ovr);

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !avail && !ovr);
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int OS          = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baud_tick,
  input  logic             rxd,
  input  logic             rx_en,
  input  logic             dbl_speed,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             rd_en,
  output logic [RX_DW-1:0] rx_data,
  output logic             rx_avail,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_ovr
);
  logic     line_s;
  logic     push;
  rx_char_t push_char;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line_s)
  );

  uart_rx_frame #(.OS(OS)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .tick      (baud_tick),
    .line      (line_s),
    .dbl       (dbl_speed),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .push      (push),
    .push_char (push_char)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .push      (push),
    .din       (push_char),
    .rd        (rd_en),
    .dout      (rx_data),
    .dout_perr (rx_perr),
    .dout_ferr (rx_ferr),
    .avail     (rx_avail),
    .ovr       (rx_ovr)
  );
endmodule

// File: tb/uart_rx_top_tb.sv
module uart_rx_top_tb;
  localparam int TDIV = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b1;
  logic       dbl_speed = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rx_data;
  logic       rx_avail, rx_perr, rx_ferr, rx_ovr;

  int checks = 0;
  int errs   = 0;

  always #10 clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;

  uart_rx_top u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd), .rx_en(rx_en),
    .dbl_speed(dbl_speed), .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en),
    .rx_data(rx_data), .rx_avail(rx_avail), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] head();
    return {21'd0, rx_avail, rx_perr, rx_ferr, rx_data};
  endfunction

  function automatic logic [31:0] exp_head(logic [7:0] b, logic pe, logic fe);
    return {21'd0, 1'b1, pe, fe, b};
  endfunction

  task automatic send(logic [7:0] b, logic with_par, logic pbit, logic stopv, int gbit);
    int bt;
    bt = (dbl_speed ? 8 : 16) * TDIV;
    rxd = 1'b0; hold(bt);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      if (gbit == i) begin
        hold(bt / 2); rxd = ~b[i]; hold(1); rxd = b[i]; hold(bt - bt / 2 - 1);
      end else hold(bt);
    end
    if (with_par) begin rxd = pbit; hold(bt); end
    rxd = stopv; hold(bt);
    rxd = 1'b1; hold(bt);
  endtask

  task automatic pop();
    rd_en = 1'b1; hold(1); rd_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R0 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic pok;
    hold(4);
    rst = 1'b0;
    hold(2);
    // R1 reset state
    check("R1", {rx_avail, rx_perr, rx_ferr, rx_ovr, rx_data}, 0);

    // R9 read of empty queue ignored
    pop();
    check("R9 empty read", {31'd0, rx_avail}, 0);

    // R2 R6 normal mode sweep, mixed parity, every third parity bit wrong
    dbl_speed = 1'b0; par_en = 1'b1;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      logic bad;
      b = 8'(i);
      par_odd = b[0];
      pok = (^b) ^ par_odd;
      bad = (i % 3 == 0);
      send(b, 1'b1, pok ^ bad, 1'b1, -1);
      check("R2 R6 sweep", head(), exp_head(b, bad, 1'b0));
      pop();
    end
    check("R9 empty after sweep", {31'd0, rx_avail}, 0);

    // R3 double-speed sweep, no parity bit
    dbl_speed = 1'b1; par_en = 1'b0;
    for (int i = 0; i < 256; i++) begin
      send(8'(255 - i), 1'b0, 1'b0, 1'b1, -1);
      check("R3 sweep", head(), exp_head(8'(255 - i), 1'b0, 1'b0));
      pop();
    end

    // R4 single-tick glitches inside data bits
    send(8'hA5, 1'b0, 1'b0, 1'b1, 3);
    check("R4 dbl glitch", head(), exp_head(8'hA5, 1'b0, 1'b0));
    pop();
    dbl_speed = 1'b0;
    send(8'h5A, 1'b0, 1'b0, 1'b1, 0);
    check("R4 glitch", head(), exp_head(8'h5A, 1'b0, 1'b0));
    pop();
    send(8'hC3, 1'b0, 1'b0, 1'b1, 7);
    check("R4 glitch msb", head(), exp_head(8'hC3, 1'b0, 1'b0));
    pop();

    // R5 short start pulse rejected
    rxd = 1'b0; hold(6); rxd = 1'b1; hold(3 * 32);
    check("R5 no store", {31'd0, rx_avail}, 0);
    send(8'h3C, 1'b0, 1'b0, 1'b1, -1);
    check("R5 recovery", head(), exp_head(8'h3C, 1'b0, 1'b0));
    pop();

    // R7 framing error still stores
    send(8'h81, 1'b0, 1'b0, 1'b0, -1);
    check("R7", head(), exp_head(8'h81, 1'b0, 1'b1));
    pop();

    // R8 flags travel with each character
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h0F, 1'b1, 1'b1, 1'b1, -1);
    send(8'hF0, 1'b1, 1'b0, 1'b0, -1);
    check("R8 first", head(), exp_head(8'h0F, 1'b1, 1'b0));
    pop();
    check("R8 second", head(), exp_head(8'hF0, 1'b0, 1'b1));
    pop();
    check("R9 drained", {31'd0, rx_avail}, 0);

    // R10 overrun
    par_en = 1'b0;
    send(8'h11, 1'b0, 1'b0, 1'b1, -1);
    send(8'h22, 1'b0, 1'b0, 1'b1, -1);
    check("R9 two held", {31'd0, rx_ovr}, 0);
    send(8'h33, 1'b0, 1'b0, 1'b1, -1);
    check("R10 head kept", head(), exp_head(8'h11, 1'b0, 1'b0));
    check("R10 ovr set", {31'd0, rx_ovr}, 1);
    pop();
    check("R10 second", head(), exp_head(8'h22, 1'b0, 1'b0));
    pop();
    check("R10 third dropped", {31'd0, rx_avail}, 0);
    check("R10 sticky", {31'd0, rx_ovr}, 1);
    rx_en = 1'b0; hold(1); rx_en = 1'b1;
    check("R10 cleared", {31'd0, rx_ovr}, 0);

    // R11 disable mid-frame
    send(8'h44, 1'b0, 1'b0, 1'b1, -1);
    rxd = 1'b0; hold(32); rxd = 1'b1; hold(16);
    rx_en = 1'b0; hold(1);
    check("R11 flush", {31'd0, rx_avail}, 0);
    rx_en = 1'b1;
    hold(12 * 32);
    check("R11 partial lost", {31'd0, rx_avail}, 0);
    send(8'h77, 1'b0, 1'b0, 1'b1, -1);
    check("R11 resume", head(), exp_head(8'h77, 1'b0, 1'b0));
    pop();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule